// File: doc/BRIEF.md
# Paired PWM Generator with Deadband

A free-running up-counter drives six edge-aligned PWM outputs. The channels are grouped two by two into three pairs, and each pair has its own routing mode. A pair can run as two independent channels, or its even channel can drive both lines. In a third mode the odd line is the inverse of the even line, and a programmable deadband holds back every rising edge so that the two lines never overlap.

Software reaches the block through a simple write-only port. Compare and modulus writes go to shadow copies. The working copies change only at a synchronisation point, which is either the counter wrap or a strobe on `sync_in`. The pair-mode and deadband settings stay locked until a key value is written.

Top module: `cpwm_timer`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, all six PWM lines and `ovf_flag` are low. The counter starts at 0, every working compare value is 0, the working modulus is 0xFFFF, all pairs are in independent mode, the deadband is 0 and the settings are locked.
- R2: The counter adds one on each clock. At a clock edge where it is equal to or above the working modulus, it goes to 0 instead. `ovf_flag` is high for exactly the one cycle that follows such an edge.
- R3: In independent mode (code 00, and also the unused code 11), line k is high in the cycle after an edge where the counter was below working compare k. A compare of 0 keeps the line low. A compare above the modulus keeps it high.
- R4: In equal mode (code 01), both lines of a pair follow the even channel's compare. The odd channel's compare has no effect on either line.
- R5: In complementary mode (code 10), the even line follows the even compare and the odd line follows its inverse. A line rises only after its level has been high for D consecutive edges, where D is the deadband value (0 to 63). Falling edges are never delayed, and both lines of the pair are never high together.
- R6: A write to a compare or modulus address changes only the shadow copy. At an edge where the counter wraps, or where `sync_in` is high, every shadow value is copied into the working set. The copy uses the shadow values as they stood before that edge.
- R7: The mode and deadband writes take effect only while the settings are unlocked. Writing 0xC35A to the key address unlocks them, and writing any other value to that address locks them. Compare and modulus writes are never locked.
- R8: The write addresses are as follows: 0 to 5 select the compare for channels 0 to 5, 6 the modulus, 7 the pair modes (bits [2p+1:2p] for pair p), 8 the deadband (bits [5:0]) and 9 the key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| sync_in | input | 1 | Strobe that loads the shadow registers into the working set |
| pwm_out | output | 6 | PWM lines; bit 2p is the even and bit 2p+1 the odd line of pair p |
| ovf_flag | output | 1 | One-cycle pulse after each counter wrap |

## Verification
The assertions assume that `rst` is held for at least one edge before the first check. They also assume that `wr_en`, `wr_addr`, `wr_data` and `sync_in` change only away from the active edge, so that every write or strobe is seen at exactly one edge. The stimulus drives all of these inputs on the falling clock edge, and each write or strobe lasts one full cycle. The modulus stays small (9 and 4), so the counter wraps many times within the run, and mode and deadband changes always go through the key sequence.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

  typedef enum logic [1:0] {
    PM_INDEP = 2'b00,
    PM_EQUAL = 2'b01,
    PM_COMPL = 2'b10,
    PM_SPARE = 2'b11
  } pair_mode_e;

  // Returns {odd, even} target levels for one pair.
  function automatic logic [1:0] pair_route(pair_mode_e m, logic lv_even, logic lv_odd);
    logic [1:0] r;
    case (m)
      PM_EQUAL: r = {lv_even, lv_even};
      PM_COMPL: r = {~lv_even, lv_even};
      default:  r = {lv_odd, lv_even};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cpwm_counter.sv
module cpwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] mod_act,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap,
  output logic             ovf_q
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  function automatic logic [CNT_W-1:0] next_count(logic [CNT_W-1:0] c, logic w);
    return w ? '0 : c + ONE;
  endfunction

  assign wrap = (cnt_q >= mod_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= next_count(cnt_q, wrap);
      ovf_q <= wrap;
    end
  end
endmodule

// File: rtl/cpwm_regfile.sv
module cpwm_regfile #(
  parameter int              CNT_W     = 16,
  parameter int              NUM_PAIRS = 3,
  parameter int              DT_W      = 6,
  parameter int              ADDR_W    = 4,
  parameter logic [CNT_W-1:0] KEY      = 16'hC35A
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic [ADDR_W-1:0]                 wr_addr,
  input  logic [CNT_W-1:0]                  wr_data,
  input  logic                              load_evt,
  output logic [2*NUM_PAIRS-1:0][CNT_W-1:0] cmp_act,
  output logic [CNT_W-1:0]                  mod_act,
  output logic [2*NUM_PAIRS-1:0]            mode_bits,
  output logic [DT_W-1:0]                   dt_q,
  output logic                              unlocked
);
  localparam int NUM_CH = 2 * NUM_PAIRS;
  localparam logic [ADDR_W-1:0] A_MOD  = ADDR_W'(NUM_CH);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(NUM_CH + 1);
  localparam logic [ADDR_W-1:0] A_DT   = ADDR_W'(NUM_CH + 2);
  localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(NUM_CH + 3);

  logic [NUM_CH-1:0][CNT_W-1:0] cmp_shadow;
  logic [CNT_W-1:0]             mod_shadow;

  // Shadowed compare registers, one per channel
  for (genvar k = 0; k < NUM_CH; k++) begin : g_cmp
    always_ff @(posedge clk) begin
      if (rst) begin
        cmp_shadow[k] <= '0;
        cmp_act[k]    <= '0;
      end else begin
        if (load_evt) cmp_act[k] <= cmp_shadow[k];
        if (wr_en && wr_addr == ADDR_W'(k)) cmp_shadow[k] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mod_shadow <= '1;
      mod_act    <= '1;
    end else begin
      if (load_evt) mod_act <= mod_shadow;
      if (wr_en && wr_addr == A_MOD) mod_shadow <= wr_data;
    end
  end

  // Protected settings and key
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_bits <= '0;
      dt_q      <= '0;
      unlocked  <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr == A_KEY) unlocked <= (wr_data == KEY);
      if (unlocked && wr_addr == A_MODE) mode_bits <= wr_data[2*NUM_PAIRS-1:0];
      if (unlocked && wr_addr == A_DT)   dt_q      <= wr_data[DT_W-1:0];
    end
  end
endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband #(
  parameter int DT_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tgt,
  input  logic            delay_en,
  input  logic [DT_W-1:0] dt,
  output logic            out_q
);
  logic [DT_W-1:0] run_q;
  logic            rise_ok;

  assign rise_ok = !delay_en || (run_q >= dt);

  always_ff @(posedge clk) begin
    if (rst || !tgt) begin
      run_q <= '0;
      out_q <= 1'b0;
    end else if (rise_ok) begin
      out_q <= 1'b1;
    end else begin
      run_q <= run_q + {{(DT_W-1){1'b0}}, 1'b1};
      out_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cpwm_pair.sv
module cpwm_pair
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DT_W  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp_even,
  input  logic [CNT_W-1:0] cmp_odd,
  input  logic [1:0]       mode,
  input  logic [DT_W-1:0]  dt,
  output logic [1:0]       pwm
);
  function automatic logic edge_level(logic [CNT_W-1:0] c, logic [CNT_W-1:0] cmp);
    return c < cmp;
  endfunction

  pair_mode_e mode_e;
  logic [1:0] tgt;
  logic       compl_en;

  assign mode_e   = pair_mode_e'(mode);
  assign compl_en = (mode_e == PM_COMPL);
  assign tgt      = pair_route(mode_e, edge_level(cnt, cmp_even), edge_level(cnt, cmp_odd));

  for (genvar s = 0; s < 2; s++) begin : g_side
    cpwm_deadband #(.DT_W(DT_W)) u_db (
      .clk      (clk),
      .rst      (rst),
      .tgt      (tgt[s]),
      .delay_en (compl_en),
      .dt       (dt),
      .out_q    (pwm[s])
    );
  end
endmodule

// File: rtl/cpwm_timer.sv
module cpwm_timer #(
  parameter int               CNT_W     = 16,
  parameter int               NUM_PAIRS = 3,
  parameter int               DT_W      = 6,
  parameter int               ADDR_W    = $clog2(2 * NUM_PAIRS + 4),
  parameter logic [CNT_W-1:0] KEY       = 16'hC35A
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [CNT_W-1:0]       wr_data,
  input  logic                   sync_in,
  output logic [2*NUM_PAIRS-1:0] pwm_out,
  output logic                   ovf_flag
);
  localparam int NUM_CH = 2 * NUM_PAIRS;

  // Named internal events, also used by the bound checker
  logic [CNT_W-1:0]             cnt_w;
  logic [CNT_W-1:0]             mod_act_w;
  logic [NUM_CH-1:0][CNT_W-1:0] cmp_act_w;
  logic [NUM_CH-1:0]            mode_w;
  logic [DT_W-1:0]              dt_w;
  logic                         unlocked_w;
  logic                         wrap_w;
  logic                         load_evt;

  assign load_evt = wrap_w | sync_in;

  cpwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .mod_act (mod_act_w),
    .cnt_q   (cnt_w),
    .wrap    (wrap_w),
    .ovf_q   (ovf_flag)
  );

  cpwm_regfile #(
    .CNT_W(CNT_W), .NUM_PAIRS(NUM_PAIRS), .DT_W(DT_W), .ADDR_W(ADDR_W), .KEY(KEY)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .load_evt  (load_evt),
    .cmp_act   (cmp_act_w),
    .mod_act   (mod_act_w),
    .mode_bits (mode_w),
    .dt_q      (dt_w),
    .unlocked  (unlocked_w)
  );

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    cpwm_pair #(.CNT_W(CNT_W), .DT_W(DT_W)) u_pair (
      .clk      (clk),
      .rst      (rst),
      .cnt      (cnt_w),
      .cmp_even (cmp_act_w[2*p]),
      .cmp_odd  (cmp_act_w[2*p+1]),
      .mode     (mode_w[2*p+1:2*p]),
      .dt       (dt_w),
      .pwm      (pwm_out[2*p+1:2*p])
    );
  end
endmodule

// File: rtl/cpwm_timer_chk.sv
module cpwm_timer_chk #(
  parameter int CNT_W     = 16,
  parameter int NUM_PAIRS = 3
) (
  input logic                   clk,
  input logic                   rst,
  input logic [CNT_W-1:0]       cnt,
  input logic [CNT_W-1:0]       mod_act,
  input logic                   ovf,
  input logic                   load_evt,
  input logic                   unlocked,
  input logic [2*NUM_PAIRS-1:0] mode_bits,
  input logic [2*NUM_PAIRS-1:0] pwm
);
  // R2: counter at or above the modulus returns to zero
  a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    (cnt >= mod_act) |=> (cnt == '0));

  // R2: the flag only appears alongside a freshly wrapped counter
  a_r2_flag_at_zero: assert property (@(posedge clk) disable iff (rst)
    ovf |-> (cnt == '0));

  // R6: the working modulus moves only at a sync point
  a_r6_mod_held: assert property (@(posedge clk) disable iff (rst)
    !load_evt |=> $stable(mod_act));

  // R7: no mode change while locked
  a_r7_mode_locked: assert property (@(posedge clk) disable iff (rst)
    !unlocked |=> $stable(mode_bits));

  // R5: a complementary pair never drives both lines high
  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_excl
    a_r5_no_overlap: assert property (@(posedge clk) disable iff (rst)
      ($past(mode_bits[2*p+1:2*p]) == 2'b10) |-> !(pwm[2*p] && pwm[2*p+1]));
  end
endmodule

bind cpwm_timer cpwm_timer_chk #(.CNT_W(CNT_W), .NUM_PAIRS(NUM_PAIRS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cnt       (cnt_w),
  .mod_act   (mod_act_w),
  .ovf       (ovf_flag),
  .load_evt  (load_evt),
  .unlocked  (unlocked_w),
  .mode_bits (mode_w),
  .pwm       (pwm_out)
);

// File: tb/cpwm_timer_test.sv
module cpwm_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        sync_in = 1'b0;
  logic [5:0]  pwm_out;
  logic        ovf_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  string phase = "R1 reset";

  always #5 clk = ~clk;

  cpwm_timer uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sync_in(sync_in), .pwm_out(pwm_out), .ovf_flag(ovf_flag)
  );

  typedef struct packed { logic [5:0] pwm; logic ovf; } exp_t;
  exp_t sb_q[$];

  // Reference state, written from the requirements
  logic [15:0] m_cnt, m_mod_sh, m_mod;
  logic [15:0] m_cmp_sh [6];
  logic [15:0] m_cmp [6];
  logic [5:0]  m_mode, m_dt, m_out;
  bit          m_unl;
  int          m_run [6];

  // Driver-side predictor: pushes one expected item per edge
  always @(posedge clk) begin : predictor
    logic [5:0] lvl, tgt;
    logic       wrapped;
    exp_t       it;
    if (rst) begin
      m_cnt = 0; m_mod_sh = 16'hFFFF; m_mod = 16'hFFFF;
      m_mode = 0; m_dt = 0; m_unl = 0; m_out = 0;
      for (int k = 0; k < 6; k++) begin m_cmp_sh[k] = 0; m_cmp[k] = 0; m_run[k] = 0; end
      it = '{pwm: 6'b0, ovf: 1'b0};
    end else begin
      for (int k = 0; k < 6; k++) lvl[k] = (m_cmp[k] > m_cnt);
      for (int p = 0; p < 3; p++) begin
        tgt[2*p] = lvl[2*p];
        if (m_mode[2*p+:2] == 2'b01)      tgt[2*p+1] = lvl[2*p];
        else if (m_mode[2*p+:2] == 2'b10) tgt[2*p+1] = !lvl[2*p];
        else                              tgt[2*p+1] = lvl[2*p+1];
      end
      for (int k = 0; k < 6; k++) begin
        if (!tgt[k]) begin m_run[k] = 0; m_out[k] = 0; end
        else if (m_mode[2*(k/2)+:2] != 2'b10 || m_run[k] >= int'(m_dt)) m_out[k] = 1;
        else begin m_run[k] = m_run[k] + 1; m_out[k] = 0; end
      end
      wrapped = !(m_cnt < m_mod);
      if (wrapped || sync_in) begin
        m_mod = m_mod_sh;
        for (int k = 0; k < 6; k++) m_cmp[k] = m_cmp_sh[k];
      end
      m_cnt = wrapped ? 16'd0 : m_cnt + 16'd1;
      if (wr_en) begin
        if (wr_addr < 4'd6) m_cmp_sh[wr_addr] = wr_data;
        if (wr_addr == 4'd6) m_mod_sh = wr_data;
        if (wr_addr == 4'd7 && m_unl) m_mode = wr_data[5:0];
        if (wr_addr == 4'd8 && m_unl) m_dt = wr_data[5:0];
        if (wr_addr == 4'd9) m_unl = (wr_data == 16'hC35A);
      end
      it = '{pwm: m_out, ovf: wrapped};
    end
    sb_q.push_back(it);
  end

  // Monitor: pops and compares away from the active edge
  always @(negedge clk) begin : monitor
    exp_t e;
    if (sb_q.size() > 0 && !done) begin
      e = sb_q.pop_front();
      checks++;
      if (pwm_out !== e.pwm || ovf_flag !== e.ovf) begin
        fails++;
        $display("FAIL %s: pwm=%b ovf=%b expected pwm=%b ovf=%b",
                 phase, pwm_out, ovf_flag, e.pwm, e.ovf);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic sync_pulse();
    sync_in = 1'b1;
    @(negedge clk);
    sync_in = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : driver
    idle(3);
    // R1: direct reset check
    checks++;
    if (pwm_out !== 6'b0 || ovf_flag !== 1'b0) begin
      fails++;
      $display("FAIL R1: pwm=%b ovf=%b expected pwm=000000 ovf=0", pwm_out, ovf_flag);
    end
    rst = 1'b0;
    idle(3);

    phase = "R3 R8 R6 R2 independent";
    wr(4'd0, 16'd3); wr(4'd1, 16'd7); wr(4'd2, 16'd0);
    wr(4'd3, 16'd12); wr(4'd4, 16'd5); wr(4'd5, 16'd9);
    wr(4'd6, 16'd9);
    idle(4);
    sync_pulse();
    idle(30);

    phase = "R7 locked write";
    wr(4'd7, 16'h0029); wr(4'd8, 16'd2);
    idle(20);

    phase = "R4 R5 R7 paired modes";
    wr(4'd9, 16'hC35A);
    wr(4'd8, 16'd2);
    wr(4'd7, 16'b11_10_01);
    idle(40);

    phase = "R5 deadband zero";
    wr(4'd8, 16'd0);
    idle(25);

    phase = "R5 deadband long";
    wr(4'd2, 16'd6); wr(4'd3, 16'd2);
    wr(4'd8, 16'd3);
    idle(40);

    phase = "R6 buffered compare";
    wr(4'd0, 16'd8);
    idle(15);
    wr(4'd4, 16'd1);
    sync_in = 1'b1; wr(4'd0, 16'd2); sync_in = 1'b0;
    idle(25);

    phase = "R7 relock";
    wr(4'd9, 16'h0000);
    wr(4'd7, 16'h0000); wr(4'd8, 16'd1);
    idle(25);

    phase = "R2 R6 new modulus";
    wr(4'd6, 16'd4);
    idle(30);

    phase = "R3 spare mode";
    wr(4'd9, 16'hC35A);
    wr(4'd7, 16'b11_11_11);
    idle(20);

    @(posedge clk);
    #1;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule